// File: doc/BRIEF.md
# Halt and Bus-Release Controller

This block sits beside a processor core and lets an outside agent, typically a DMA engine, stop the core and take over the system bus. The agent pulls an active-low halt request. The controller waits until the core reports the last cycle of an instruction, then freezes the core and raises a bus-available status. While that status is high, it withdraws the core's drive from the address bus, the data bus and the read/write line, and it forces the valid-memory-address strobe to zero.

The controller samples the halt request through a register. A request therefore counts at an instruction boundary only if it was already low at the clock edge before the final edge of that instruction. A request that arrives later lets the core run one more instruction.

Interrupt inputs are captured by the controller. A low level on the maskable line or a falling edge on the non-maskable line is held in a latch. The latched request is presented to the core only while the core runs, and it stays pending until the core acknowledges it. An interrupt that arrives during a halt is therefore serviced after the core resumes.

Top module: `halt_bus_ctl`

## Requirements
- R1: After reset, bus_avail is 0, core_run is 1, and irq_req and nmi_req are 0.
- R2: The controller registers halt_n on every clock edge. If that registered value is low, bus_avail goes to 1 at the next edge where instr_last is 1. At edges where instr_last is 0, the core never halts.
- R3: If halt_n first goes low at an edge where instr_last is 1, the controller does not halt at that edge. It halts at the following edge where instr_last is 1.
- R4: While bus_avail is 1, the outputs vma, addr_oe, data_oe and rw_oe are all 0.
- R5: While bus_avail is 0, addr_oe and rw_oe are 1 and vma equals core_vma. data_oe is 1 exactly when core_rw is 0 (core_rw: 1 = read, 0 = write).
- R6: While halted, the controller stays halted as long as the registered halt_n is low. If halt_n is sampled high at edge k, bus_avail drops after edge k+1. core_run is always the inverse of bus_avail.
- R7: Any clock edge that sees irq_n low sets an interrupt latch, even if irq_n rises again before the halt ends. irq_req shows the latch only while bus_avail is 0. The latch clears at an edge with irq_ack high and irq_n high.
- R8: A falling edge on nmi_n sets a second latch. nmi_req shows that latch only while bus_avail is 0. The latch clears at an edge with nmi_ack high. A level held low afterwards does not set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_n | input | 1 | Halt request, active low, level sensitive |
| instr_last | input | 1 | Core is in the last cycle of an instruction |
| core_vma | input | 1 | Core's valid-address strobe |
| core_rw | input | 1 | Core's direction, 1 = read |
| irq_n | input | 1 | Maskable interrupt, active low level |
| nmi_n | input | 1 | Non-maskable interrupt, falling edge |
| irq_ack | input | 1 | Core takes the maskable interrupt |
| nmi_ack | input | 1 | Core takes the non-maskable interrupt |
| bus_avail | output | 1 | Core halted, bus released |
| core_run | output | 1 | Core may advance |
| vma | output | 1 | Gated valid-address strobe |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Data bus drive enable |
| rw_oe | output | 1 | Read/write line drive enable |
| irq_req | output | 1 | Pending maskable interrupt to core |
| nmi_req | output | 1 | Pending non-maskable interrupt to core |

## Verification
Some behaviours are checked by assertions on every cycle:
- the bus drive enables and the strobe stay off whenever the bus is released;
- a halt only begins on a cycle that the core flagged as an instruction end;
- the halted state holds while the request stays sampled low;
- pending interrupts are never shown while halted, and they persist until acknowledged.

Other behaviours only the bench scenarios can show. These are the one-edge timing difference between an early and a late halt request, the exact two-edge release latency, and the rule that a held-low non-maskable line does not re-arm after acknowledgement. A cycle-accurate model in the bench covers the random mix.

// File: rtl/halt_ctl_pkg.sv
package halt_ctl_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_e;

    typedef struct packed {
        run_state_e st;
        logic       req;
    } seq_s;

    typedef struct packed {
        logic irq;
        logic nmi;
        logic nmi_prev;
    } intr_s;
endpackage

// File: rtl/halt_seq.sv
module halt_seq
    import halt_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_n,
    input  logic instr_last,
    output logic halted
);
    seq_s q, d;

    always_comb begin
        d     = q;
        d.req = ~halt_n;
        case (q.st)
            ST_RUN:  if (instr_last && q.req) d.st = ST_HALT;
            ST_HALT: if (!q.req)              d.st = ST_RUN;
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_RUN;
            q.req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign halted = (q.st == ST_HALT);

    // R2: a halt begins only on an instruction's final cycle
    a_r2_halt_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(instr_last));

    // R6: halted state holds while the sampled request is low
    a_r6_hold_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && q.req) |=> halted);
endmodule

// File: rtl/int_latch.sv
module int_latch
    import halt_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halted,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic irq_ack,
    input  logic nmi_ack,
    output logic irq_req,
    output logic nmi_req
);
    intr_s q, d;

    always_comb begin
        d          = q;
        d.nmi_prev = nmi_n;
        if (!irq_n)               d.irq = 1'b1;
        else if (irq_ack)         d.irq = 1'b0;
        if (q.nmi_prev && !nmi_n) d.nmi = 1'b1;
        else if (nmi_ack)         d.nmi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.irq      <= 1'b0;
            q.nmi      <= 1'b0;
            q.nmi_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign irq_req = q.irq & ~halted;
    assign nmi_req = q.nmi & ~halted;

    // R7: a latched maskable request persists until acknowledged
    a_r7_irq_persist: assert property (@(posedge clk) disable iff (!rst_n)
        (q.irq && !irq_ack) |=> q.irq);

    // R8: the non-maskable latch is only set by a falling edge
    a_r8_nmi_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.nmi) |-> ($past(q.nmi_prev) && !$past(nmi_n)));

    // R7, R8: nothing is offered to the core while halted
    a_r7_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!irq_req && !nmi_req));
endmodule

// File: rtl/bus_gate.sv
module bus_gate (
    input  logic halted,
    input  logic core_vma,
    input  logic core_rw,
    output logic vma,
    output logic addr_oe,
    output logic data_oe,
    output logic rw_oe
);
    always_comb begin
        vma     = core_vma & ~halted;
        addr_oe = ~halted;
        rw_oe   = ~halted;
        data_oe = ~halted & ~core_rw;
    end
endmodule

// File: rtl/halt_bus_ctl.sv
module halt_bus_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_n,
    input  logic instr_last,
    input  logic core_vma,
    input  logic core_rw,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic irq_ack,
    input  logic nmi_ack,
    output logic bus_avail,
    output logic core_run,
    output logic vma,
    output logic addr_oe,
    output logic data_oe,
    output logic rw_oe,
    output logic irq_req,
    output logic nmi_req
);
    logic halted;

    halt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_n     (halt_n),
        .instr_last (instr_last),
        .halted     (halted)
    );

    int_latch u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .halted  (halted),
        .irq_n   (irq_n),
        .nmi_n   (nmi_n),
        .irq_ack (irq_ack),
        .nmi_ack (nmi_ack),
        .irq_req (irq_req),
        .nmi_req (nmi_req)
    );

    bus_gate u_gate (
        .halted   (halted),
        .core_vma (core_vma),
        .core_rw  (core_rw),
        .vma      (vma),
        .addr_oe  (addr_oe),
        .data_oe  (data_oe),
        .rw_oe    (rw_oe)
    );

    assign bus_avail = halted;
    assign core_run  = ~halted;

    // R4: released bus means every drive enable and the strobe are off
    a_r4_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        bus_avail |-> (!vma && !addr_oe && !data_oe && !rw_oe));

    // R5: running core owns the address and direction lines
    a_r5_bus_owned: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_avail |-> (addr_oe && rw_oe && (vma == core_vma)));
endmodule

// File: tb/halt_bus_ctl_bench.sv
module halt_bus_ctl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_n = 1'b1, instr_last = 1'b0, core_vma = 1'b0, core_rw = 1'b1;
    logic irq_n = 1'b1, nmi_n = 1'b1, irq_ack = 1'b0, nmi_ack = 1'b0;
    logic bus_avail, core_run, vma, addr_oe, data_oe, rw_oe, irq_req, nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit m_hreq = 0, m_halted = 0, m_nprev = 1, m_irq = 0, m_nmi = 0;

    always #10 clk = ~clk;

    halt_bus_ctl u_halt_bus_ctl (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .instr_last(instr_last),
        .core_vma(core_vma), .core_rw(core_rw), .irq_n(irq_n), .nmi_n(nmi_n),
        .irq_ack(irq_ack), .nmi_ack(nmi_ack), .bus_avail(bus_avail),
        .core_run(core_run), .vma(vma), .addr_oe(addr_oe), .data_oe(data_oe),
        .rw_oe(rw_oe), .irq_req(irq_req), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_halted(bit h, bit rq, bit last);
        return h ? rq : (last && rq);
    endfunction

    // one clock: update model at the edge, compare all outputs after it
    task automatic step();
        @(posedge clk);
        m_halted = next_halted(m_halted, m_hreq, instr_last);
        m_hreq   = !halt_n;
        if (!irq_n) m_irq = 1; else if (irq_ack) m_irq = 0;
        if (m_nprev && !nmi_n) m_nmi = 1; else if (nmi_ack) m_nmi = 0;
        m_nprev  = nmi_n;
        @(negedge clk);
        chk("R2/R3/R6 bus_avail", bus_avail, m_halted);
        chk("R6 core_run", core_run, !m_halted);
        chk("R4/R5 vma", vma, core_vma && !m_halted);
        chk("R4/R5 addr_oe", addr_oe, !m_halted);
        chk("R4/R5 rw_oe", rw_oe, !m_halted);
        chk("R4/R5 data_oe", data_oe, !m_halted && !core_rw);
        chk("R7 irq_req", irq_req, m_irq && !m_halted);
        chk("R8 nmi_req", nmi_req, m_nmi && !m_halted);
    endtask

    task automatic go_halt();
        halt_n = 0; instr_last = 0; step();
        instr_last = 1; step(); instr_last = 0;
    endtask

    task automatic release_halt();
        halt_n = 1; step(); step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 bus_avail", bus_avail, 1'b0);
        chk("R1 core_run", core_run, 1'b1);
        chk("R1 irq_req", irq_req, 1'b0);
        chk("R1 nmi_req", nmi_req, 1'b0);

        // R2 early request halts at next boundary, not before
        halt_n = 0; instr_last = 0; step();
        step(); chk("R2 no halt off boundary", bus_avail, 1'b0);
        instr_last = 1; step(); chk("R2 halt at boundary", bus_avail, 1'b1);
        instr_last = 0; core_vma = 1; core_rw = 0; step();
        chk("R4 vma off", vma, 1'b0);
        chk("R4 data_oe off", data_oe, 1'b0);
        // R6 release latency
        halt_n = 1; step(); chk("R6 still halted one edge", bus_avail, 1'b1);
        step(); chk("R6 resumed", bus_avail, 1'b0);
        chk("R5 data_oe on write", data_oe, 1'b1);
        chk("R5 vma follows core", vma, 1'b1);

        // R3 late request: one more instruction
        halt_n = 0; instr_last = 1; step();
        chk("R3 late request ignored", bus_avail, 1'b0);
        instr_last = 0; step(); chk("R3 running next instr", bus_avail, 1'b0);
        instr_last = 1; step(); chk("R3 halts one instr later", bus_avail, 1'b1);
        instr_last = 0; release_halt();

        // R7 interrupt during halt
        go_halt();
        irq_n = 0; step(); irq_n = 1; step(); step();
        chk("R7 irq hidden while halted", irq_req, 1'b0);
        release_halt();
        chk("R7 irq shown after resume", irq_req, 1'b1);
        step(); chk("R7 irq held", irq_req, 1'b1);
        irq_ack = 1; step(); irq_ack = 0;
        chk("R7 irq cleared by ack", irq_req, 1'b0);

        // R8 nmi edge during halt, held low afterwards
        go_halt();
        nmi_n = 0; step(); step();
        chk("R8 nmi hidden while halted", nmi_req, 1'b0);
        release_halt();
        chk("R8 nmi shown after resume", nmi_req, 1'b1);
        nmi_ack = 1; step(); nmi_ack = 0;
        chk("R8 nmi cleared", nmi_req, 1'b0);
        step(); step(); chk("R8 low level no re-arm", nmi_req, 1'b0);
        nmi_n = 1; step();

        // random mix against the model
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            halt_n     = ($urandom % 8) != 0 ? halt_n : ~halt_n;
            instr_last = ($urandom % 3) == 0;
            core_vma   = $urandom % 2;
            core_rw    = $urandom % 2;
            irq_n      = ($urandom % 10) != 0;
            nmi_n      = ($urandom % 6) == 0 ? ~nmi_n : nmi_n;
            irq_ack    = ($urandom % 4) == 0;
            nmi_ack    = ($urandom % 4) == 0;
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule